// File: doc/BRIEF.md
# Floating Register High-Half Mover

This block moves a 32-bit word between the integer side of a core and the upper half of a floating-point register. It holds its own file of 32 floating registers of 64 bits. A mode input picks how that file is seen. In wide mode each register is a full 64-bit value. In paired mode each register is 32 bits wide, and the upper half of a double lives in the odd register that follows an even one.

The pipeline presents one instruction word per cycle, qualified by `cmd_valid`. A word is acted on only if it is one of the two move encodings. A move-from returns a sign-extended result in the same cycle. A move-to changes the register file at the next rising clock edge.

In paired mode an odd register number is not a legal target. A move-from on one returns a fixed poison word. A move-to on one writes a different fixed poison word into that odd register. A small state machine flags either case with a one-cycle warning in the following cycle. It has three states:
- `ST_QUIET`: no warning.
- `ST_WARN_FROM`: the last cycle held an odd move-from.
- `ST_WARN_TO`: the last cycle held an odd move-to.

Every state takes the same transitions. An odd paired move-from leads to `ST_WARN_FROM`. An odd paired move-to leads to `ST_WARN_TO`. Any other cycle leads back to `ST_QUIET`.

Top module: `fhm_mover`

## Requirements
- R1: The block acts on a word only when all of the following hold: `cmd_valid` is high, bits 31:26 are 010001, bits 10:0 are zero, and bits 25:21 are either 00011 (move-from) or 00111 (move-to). The floating register index is in bits 15:11 and the integer register index is in bits 20:16. Any other word has no effect: `rd_valid` stays low, no register changes and no warning is raised.
- R2: In wide mode (`wide_mode`=1), a move-from raises `rd_valid` in the same cycle. `rd_data` then carries bits 63:32 of the selected register, sign-extended to 64 bits.
- R3: In wide mode, a move-to replaces bits 63:32 of the selected register with `int_lo` and leaves bits 31:0 unchanged. The change is visible from the next cycle.
- R4: In paired mode with an even index n, a move-from returns the 32-bit register n+1, sign-extended.
- R5: In paired mode with an even index n, a move-to writes `int_lo` into register n+1. Register n is unchanged.
- R6: In paired mode with an odd index, a move-from returns 0x000000000BADF00D.
- R7: In paired mode with an odd index, a move-to writes 0xDEADC0DE into that odd register itself.
- R8: In the cycle after an odd-index paired move, `warn` is high for exactly that cycle. `warn_to` is 1 for a move-to and 0 for a move-from. Back-to-back odd moves keep `warn` high, with `warn_to` following each one.
- R9: Reset clears every floating register to zero and holds `warn` low.
- R10: Both modes share one storage. Paired register k is bits 31:0 of wide register k. A wide move-to therefore never changes what a paired move-from reads, and the mode may change on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Instruction word is present this cycle |
| cmd_word | input | 32 | Instruction word |
| wide_mode | input | 1 | 1: 64-bit registers; 0: paired 32-bit registers |
| int_lo | input | 32 | Low word of the source integer register for a move-to |
| rd_valid | output | 1 | A move-from result is on rd_data this cycle |
| rd_data | output | 64 | Sign-extended move-from result |
| int_idx | output | 5 | Integer register index taken from the word |
| warn | output | 1 | One-cycle flag for an odd-index paired move |
| warn_to | output | 1 | Direction of the flagged move: 1 move-to, 0 move-from |

## Verification
The hardest case to reach from the ports is a move in one mode that observes a write made in the other mode. The bench also has to catch consecutive odd-index moves whose warning direction flips from one cycle to the next. Directed sequences cover these. They write an even/odd pair in wide mode and then read it in paired mode, and they issue odd move-from and move-to words on adjacent cycles. A long stretch follows in which the mode, the direction, the index parity and malformed words are drawn at random. A shadow model predicts each result and warning for this stretch.

// File: rtl/fhm_pkg.sv
package fhm_pkg;

    localparam int WORD_W = 64;
    localparam int HALF_W = WORD_W / 2;
    localparam int FREG_N = 32;
    localparam int FIDX_W = $clog2(FREG_N);
    localparam int IIDX_W = 5;

    localparam logic [5:0] COP_MAJOR = 6'b010001;
    localparam logic [4:0] SUB_FROM  = 5'b00011;
    localparam logic [4:0] SUB_TO    = 5'b00111;

    localparam logic [HALF_W-1:0] POISON_FROM = 32'h0BADF00D;
    localparam logic [HALF_W-1:0] POISON_TO   = 32'hDEADC0DE;

    typedef enum logic [1:0] {
        XF_NONE = 2'd0,
        XF_FROM = 2'd1,
        XF_TO   = 2'd2
    } xfer_e;

    typedef struct packed {
        xfer_e              kind;
        logic [IIDX_W-1:0]  int_idx;
        logic [FIDX_W-1:0]  fp_idx;
    } xfer_t;

endpackage

// File: rtl/fhm_decode.sv
module fhm_decode
    import fhm_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] word,
    output xfer_t       cmd
);

    logic shape_ok;

    always_comb begin
        shape_ok    = valid && (word[31:26] == COP_MAJOR) && (word[10:0] == 11'd0);
        cmd.int_idx = word[20:16];
        cmd.fp_idx  = word[15:11];
        cmd.kind    = XF_NONE;
        if (shape_ok) begin
            if (word[25:21] == SUB_FROM) begin
                cmd.kind = XF_FROM;
            end else if (word[25:21] == SUB_TO) begin
                cmd.kind = XF_TO;
            end
        end
    end

endmodule

// File: rtl/fhm_regfile.sv
module fhm_regfile #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int HW = WIDTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_word,
    input  logic          we,
    input  logic [AW-1:0] wr_idx,
    input  logic          wr_hi,
    input  logic [HW-1:0] wr_half
);

    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic hit;
        assign hit = we && (wr_idx == AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (hit) begin
                if (wr_hi) begin
                    mem[g][WIDTH-1:HW] <= wr_half;
                end else begin
                    mem[g][HW-1:0] <= wr_half;
                end
            end
        end
    end

    assign rd_word = mem[rd_idx];

    // R3: an upper-half write lands and the lower half is kept
    p_hi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_hi) |=> (mem[$past(wr_idx)][WIDTH-1:HW] == $past(wr_half))
                       && (mem[$past(wr_idx)][HW-1:0] == $past(mem[wr_idx][HW-1:0])));

    // R5: a lower-half write lands and the upper half is kept
    p_lo_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wr_hi) |=> (mem[$past(wr_idx)][HW-1:0] == $past(wr_half))
                        && (mem[$past(wr_idx)][WIDTH-1:HW] == $past(mem[wr_idx][WIDTH-1:HW])));

    // R9: the first cycle out of reset reads zero everywhere
    p_reset_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_word == '0));

endmodule

// File: rtl/fhm_warn_fsm.sv
module fhm_warn_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic odd_hit,
    input  logic odd_to,
    output logic warn,
    output logic warn_to
);

    typedef enum logic [1:0] {
        ST_QUIET     = 2'd0,
        ST_WARN_FROM = 2'd1,
        ST_WARN_TO   = 2'd2
    } warn_st_e;

    warn_st_e state_q;
    warn_st_e state_d;
    warn_st_e odd_target;

    assign odd_target = odd_hit ? (odd_to ? ST_WARN_TO : ST_WARN_FROM) : ST_QUIET;

    always_comb begin
        unique case (state_q)
            ST_QUIET:     state_d = odd_target;
            ST_WARN_FROM: state_d = odd_target;
            ST_WARN_TO:   state_d = odd_target;
            default:      state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_QUIET:     begin warn = 1'b0; warn_to = 1'b0; end
            ST_WARN_FROM: begin warn = 1'b1; warn_to = 1'b0; end
            ST_WARN_TO:   begin warn = 1'b1; warn_to = 1'b1; end
            default:      begin warn = 1'b0; warn_to = 1'b0; end
        endcase
    end

    // R8: an odd paired move is flagged in the next cycle with its direction
    p_warn_after_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        odd_hit |=> (warn && (warn_to == $past(odd_to))));

    // R8: the flag lasts one cycle unless another odd move follows
    p_warn_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !odd_hit |=> !warn);

endmodule

// File: rtl/fhm_mover.sv
module fhm_mover
    import fhm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [31:0]       cmd_word,
    input  logic              wide_mode,
    input  logic [31:0]       int_lo,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic [4:0]        int_idx,
    output logic              warn,
    output logic              warn_to
);

    xfer_t              cmd;
    logic [FIDX_W-1:0]  fs;
    logic [FIDX_W-1:0]  fs_pair;
    logic               odd_paired;
    logic [FIDX_W-1:0]  rf_rd_idx;
    logic [WORD_W-1:0]  rf_rd_word;
    logic               rf_we;
    logic [FIDX_W-1:0]  rf_wr_idx;
    logic               rf_wr_hi;
    logic [HALF_W-1:0]  rf_wr_half;
    logic [HALF_W-1:0]  pick;

    fhm_decode u_decode (
        .valid (cmd_valid),
        .word  (cmd_word),
        .cmd   (cmd)
    );

    assign fs         = cmd.fp_idx;
    assign fs_pair    = fs | FIDX_W'(1);
    assign odd_paired = !wide_mode && fs[0];
    assign int_idx    = cmd.int_idx;

    // Read side: wide reads the named entry, paired reads its odd partner
    assign rf_rd_idx = wide_mode ? fs : fs_pair;

    always_comb begin
        if (wide_mode) begin
            pick = rf_rd_word[WORD_W-1:HALF_W];
        end else if (fs[0]) begin
            pick = POISON_FROM;
        end else begin
            pick = rf_rd_word[HALF_W-1:0];
        end
    end

    assign rd_valid = (cmd.kind == XF_FROM);
    assign rd_data  = rd_valid ? {{HALF_W{pick[HALF_W-1]}}, pick} : '0;

    // Write side
    assign rf_we      = (cmd.kind == XF_TO);
    assign rf_wr_hi   = wide_mode;
    assign rf_wr_idx  = (wide_mode || fs[0]) ? fs : fs_pair;
    assign rf_wr_half = odd_paired ? POISON_TO : int_lo;

    fhm_regfile #(
        .DEPTH (FREG_N),
        .WIDTH (WORD_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rf_rd_idx),
        .rd_word (rf_rd_word),
        .we      (rf_we),
        .wr_idx  (rf_wr_idx),
        .wr_hi   (rf_wr_hi),
        .wr_half (rf_wr_half)
    );

    fhm_warn_fsm u_warn (
        .clk     (clk),
        .rst_n   (rst_n),
        .odd_hit (odd_paired && (cmd.kind != XF_NONE)),
        .odd_to  (cmd.kind == XF_TO),
        .warn    (warn),
        .warn_to (warn_to)
    );

    // R1: a read never writes the file
    p_from_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !rf_we);

    // R1: nothing happens without a valid word
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (!rd_valid && !rf_we));

    // R7: an odd paired write stores the poison word in the odd entry
    p_odd_poison_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && odd_paired) |-> (rf_wr_idx == fs) && (rf_wr_half == POISON_TO));

endmodule

// File: tb/sim_fhm_mover.sv
module sim_fhm_mover;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        cmd_valid;
    logic [31:0] cmd_word;
    logic        wide_mode;
    logic [31:0] int_lo;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [4:0]  int_idx;
    logic        warn;
    logic        warn_to;

    fhm_mover u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .wide_mode (wide_mode),
        .int_lo    (int_lo),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .int_idx   (int_idx),
        .warn      (warn),
        .warn_to   (warn_to)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    logic [63:0] sh [32];

    bit          q_has [$];
    logic [63:0] q_val [$];
    bit          q_odd [$];
    bit          q_to  [$];
    logic [4:0]  q_rt  [$];
    string       q_req [$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input bit to, input logic [4:0] rt, input logic [4:0] fs);
        return {6'b010001, (to ? 5'b00111 : 5'b00011), rt, fs, 11'd0};
    endfunction

    // Driver: drives one cycle and pushes what the monitor must see
    task automatic step(input bit v, input logic [31:0] w, input logic [31:0] lo,
                        input bit wide, input string req);
        logic [4:0]  fs;
        logic [31:0] v32;
        bit ok;
        bit isf;
        bit ist;
        @(negedge clk);
        cmd_valid = v;
        cmd_word  = w;
        int_lo    = lo;
        wide_mode = wide;
        fs  = w[15:11];
        ok  = v && (w[31:26] == 6'b010001) && (w[10:0] == 11'd0);
        isf = ok && (w[25:21] == 5'b00011);
        ist = ok && (w[25:21] == 5'b00111);
        v32 = 32'd0;
        if (isf) begin
            if (wide) v32 = sh[fs][63:32];
            else if (fs[0]) v32 = 32'h0BADF00D;
            else v32 = sh[fs | 5'd1][31:0];
        end
        q_has.push_back(isf);
        q_val.push_back({{32{v32[31]}}, v32});
        q_odd.push_back((isf || ist) && !wide && fs[0]);
        q_to.push_back(ist);
        q_rt.push_back(w[20:16]);
        q_req.push_back(req);
        if (ist) begin
            if (wide) sh[fs][63:32] = lo;
            else if (fs[0]) sh[fs][31:0] = 32'hDEADC0DE;
            else sh[fs | 5'd1][31:0] = lo;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'd0, 32'd0, 1'b1, "R1");
    endtask

    // Monitor: pops one expected item per cycle and compares
    initial begin
        bit prev_odd;
        bit prev_to;
        prev_odd = 1'b0;
        prev_to  = 1'b0;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD / 4);
            if (mon_on) begin
                bit has;
                logic [63:0] val;
                bit odd;
                bit to;
                logic [4:0] rt;
                string req;
                if (q_has.size() > 0) begin
                    has = q_has.pop_front();
                    val = q_val.pop_front();
                    odd = q_odd.pop_front();
                    to  = q_to.pop_front();
                    rt  = q_rt.pop_front();
                    req = q_req.pop_front();
                end else begin
                    has = 1'b0; val = '0; odd = 1'b0; to = 1'b0; rt = 5'd0; req = "R1";
                end
                chk(rd_valid == has, {req, " rd_valid"}, 64'(rd_valid), 64'(has));
                if (has) begin
                    chk(rd_data == val, {req, " rd_data"}, rd_data, val);
                    chk(int_idx == rt, "R1 int_idx", 64'(int_idx), 64'(rt));
                end
                chk(warn == prev_odd, "R8 warn", 64'(warn), 64'(prev_odd));
                if (prev_odd) chk(warn_to == prev_to, "R8 warn_to", 64'(warn_to), 64'(prev_to));
                prev_odd = odd;
                prev_to  = to;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) sh[i] = '0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; wide_mode = 1'b1; int_lo = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R9 reset rd_valid", 64'(rd_valid), 64'd0);
        chk(warn == 1'b0, "R9 reset warn", 64'(warn), 64'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R9: every register reads zero after reset
        for (int i = 0; i < 32; i++) step(1'b1, mk(1'b0, 5'(i), 5'(i)), 32'd0, 1'b1, "R9");

        // R2 R3: wide write of a negative and a positive upper half
        step(1'b1, mk(1'b1, 5'd4, 5'd3), 32'h87654321, 1'b1, "R3");
        step(1'b1, mk(1'b0, 5'd2, 5'd3), 32'd0, 1'b1, "R2");
        step(1'b1, mk(1'b1, 5'd1, 5'd10), 32'h12345678, 1'b1, "R3");
        step(1'b1, mk(1'b0, 5'd7, 5'd10), 32'd0, 1'b1, "R2");

        // R4 R5: paired even write goes to n+1, n and upper half untouched
        step(1'b1, mk(1'b1, 5'd9, 5'd6), 32'hABCD0123, 1'b0, "R5");
        step(1'b1, mk(1'b0, 5'd9, 5'd6), 32'd0, 1'b0, "R4");
        step(1'b1, mk(1'b0, 5'd9, 5'd7), 32'd0, 1'b1, "R5");
        step(1'b1, mk(1'b0, 5'd9, 5'd6), 32'd0, 1'b1, "R5");

        // R6 R8: odd paired read returns the poison word and warns
        step(1'b1, mk(1'b0, 5'd3, 5'd9), 32'd0, 1'b0, "R6");
        idle(2);

        // R7 R8: odd paired write stores poison in the odd register
        step(1'b1, mk(1'b1, 5'd3, 5'd11), 32'h11111111, 1'b0, "R7");
        step(1'b1, mk(1'b0, 5'd3, 5'd10), 32'd0, 1'b0, "R7");
        idle(1);

        // R8: back-to-back odd moves with flipping direction
        step(1'b1, mk(1'b0, 5'd0, 5'd1), 32'd0, 1'b0, "R8");
        step(1'b1, mk(1'b1, 5'd0, 5'd3), 32'h5A5A5A5A, 1'b0, "R8");
        step(1'b1, mk(1'b0, 5'd0, 5'd31), 32'd0, 1'b0, "R8");
        idle(2);

        // R10: wide upper write does not change paired view; mode flips every cycle
        step(1'b1, mk(1'b0, 5'd0, 5'd2), 32'd0, 1'b0, "R10");
        step(1'b1, mk(1'b1, 5'd0, 5'd11), 32'h0000BEEF, 1'b1, "R10");
        step(1'b1, mk(1'b0, 5'd0, 5'd10), 32'd0, 1'b0, "R10");
        step(1'b1, mk(1'b0, 5'd0, 5'd11), 32'd0, 1'b1, "R10");

        // R1: malformed and unqualified words have no effect
        step(1'b1, {6'b010000, 5'b00111, 5'd0, 5'd20, 11'd0}, 32'hFFFFFFFF, 1'b1, "R1");
        step(1'b1, mk(1'b1, 5'd0, 5'd20) | 32'd1, 32'hFFFFFFFF, 1'b1, "R1");
        step(1'b1, {6'b010001, 5'b00100, 5'd0, 5'd20, 11'd0}, 32'hFFFFFFFF, 1'b1, "R1");
        step(1'b0, mk(1'b1, 5'd0, 5'd20), 32'hFFFFFFFF, 1'b1, "R1");
        step(1'b0, mk(1'b0, 5'd0, 5'd21), 32'd0, 1'b0, "R1");
        step(1'b1, mk(1'b0, 5'd0, 5'd20), 32'd0, 1'b1, "R1");
        step(1'b1, mk(1'b0, 5'd0, 5'd20), 32'd0, 1'b0, "R1");

        // Mixed stretch against the shadow model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            bit wide;
            logic [4:0] fs;
            wide = ($urandom % 3) == 0 ? i[0] : 1'($urandom);
            fs   = 5'($urandom);
            w    = mk(1'($urandom), 5'($urandom), fs);
            if (($urandom % 8) == 0) w[25:21] = 5'($urandom);
            if (($urandom % 10) == 0) w[10:0] = 11'($urandom);
            step(($urandom % 6) != 0, w, $urandom, wide, "R10");
        end
        idle(3);

        @(negedge clk);
        mon_on = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule